// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers the event sources of a host bus bridge into one 32-bit status register and turns them into a single level-sensitive interrupt for the CPU. Single-cycle pulses from the descriptor engines and from the bus-abort detector set their status bits directly. The active-low interrupt line of an external device on the bus is first brought into the local clock domain, and while it is asserted it sets its own status bit.

Software reaches three registers through a simple register port: status, mask and global enable. It clears status bits by writing ones to them. The interrupt output is registered. It stays high while any status bit that is also set in the mask is pending and the global enable is on. A second output gives the index of the lowest-numbered pending unmasked source, so that a handler can dispatch without scanning the register.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, status, mask and global enable all read 0, `irq_o` is 0 and `pend_vld` is 0.
- R2: Offset 0x504 holds the mask and offset 0x508 holds the global enable in bit 0. Only bits 15:0, 25 and 26 of status and mask exist. Every other bit, and bits 31:1 of the enable register, read as 0.
- R3: A write to the status register at offset 0x500 clears each status bit written with 1. Bits written with 0 keep their value. A status bit falls only through such a write.
- R4: A pulse on `desc_evt[i]` sets status bit i, for i from 0 to 15. A pulse on `bus_abort` sets status bit 26. These bits become visible one clock edge after the pulse.
- R5: When a source sets a bit in the same cycle that a write-one clears it, the bit stays set.
- R6: `irq_o` is 1 exactly when (status AND mask) is nonzero and enable bit 0 is 1. It follows the registers at the same clock edge as they change.
- R7: `ext_irq_n` is active low and passes through a two-stage synchronizer. Status bit 25 is set on the third clock edge after the line falls. The bit is set again on every cycle while the line stays low, so a clear takes effect only once the line has been high for two edges.
- R8: `pend_vld` is 1 when (status AND mask) is nonzero, whatever the global enable is. `pend_idx` is then the lowest set bit position of (status AND mask).
- R9: Reads from any offset other than 0x500, 0x504 and 0x508 return 0. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| desc_evt | input | 16 | Descriptor engine event pulses |
| bus_abort | input | 1 | Bus abort event pulse |
| ext_irq_n | input | 1 | External device interrupt line, asynchronous, active low |
| irq_o | output | 1 | Registered level interrupt to the CPU |
| pend_idx | output | 5 | Lowest pending unmasked status bit |
| pend_vld | output | 1 | `pend_idx` is valid |

## Verification
The bench drives an event and a write-one clear onto the same bit in the same cycle. A design that let the clear win would lose the event, so the read-back would show the bit as 0. A write of zeros to status and a write of ones into unused bits are read back. This exposes a design that treated the status write as a plain store or that kept bits that do not exist. The external line is sampled exactly one edge before and at the third edge after it falls, and a clear is tried while the line is still held low. A synchronizer with the wrong depth, or a status bit that does not set again while the line stays low, fails at one of those points. Masking the lowest pending bit and dropping the global enable while sources remain pending checks that `pend_idx` skips masked bits and that only `irq_o` depends on the enable.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned OFS_W     = 12;
    localparam int unsigned IDX_W     = $clog2(REG_W);
    localparam int unsigned DESC_W    = 16;
    localparam int unsigned EXT_POS   = 25;
    localparam int unsigned ABORT_POS = 26;

    // offsets software decodes
    localparam logic [OFS_W-1:0] OFS_STATUS = 12'h500;
    localparam logic [OFS_W-1:0] OFS_MASK   = 12'h504;
    localparam logic [OFS_W-1:0] OFS_ENABLE = 12'h508;

    // bits that physically exist in status and mask
    localparam logic [REG_W-1:0] IMPL_BITS =
        ((REG_W'(1) << DESC_W) - REG_W'(1)) |
        (REG_W'(1) << EXT_POS) |
        (REG_W'(1) << ABORT_POS);

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_MASK,
        SEL_ENABLE
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
        if (ofs == OFS_STATUS)      return SEL_STATUS;
        else if (ofs == OFS_MASK)   return SEL_MASK;
        else if (ofs == OFS_ENABLE) return SEL_ENABLE;
        else                        return SEL_NONE;
    endfunction

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    output logic active
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_n};
        end
    end

    assign active = ~chain_q[LAST];

endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
    import irq_agg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] set_vec,
    output logic [REG_W-1:0] status_q,
    output logic [REG_W-1:0] mask_q,
    output logic             en_q,
    output logic [REG_W-1:0] status_n,
    output logic [REG_W-1:0] mask_n,
    output logic             en_n
);
    logic [REG_W-1:0] clr_vec;

    always_comb begin
        clr_vec  = (wr && sel == SEL_STATUS) ? (wdata & IMPL_BITS) : '0;
        // a set in the same cycle overrides the clear
        status_n = ((status_q & ~clr_vec) | set_vec) & IMPL_BITS;
        mask_n   = (wr && sel == SEL_MASK) ? (wdata & IMPL_BITS) : mask_q;
        en_n     = (wr && sel == SEL_ENABLE) ? wdata[0] : en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
            en_q     <= 1'b0;
        end else begin
            status_q <= status_n;
            mask_q   <= mask_n;
            en_q     <= en_n;
        end
    end

    // R3: a status bit may fall only where software wrote a one
    a_r3_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(status_q) & ~status_q & ~$past(clr_vec)) == '0));

    // R5: every requested set is present after the edge
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status_q & $past(set_vec & IMPL_BITS)) == $past(set_vec & IMPL_BITS)));

    // R2: nonexistent bits stay zero
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~IMPL_BITS) == '0) && ((mask_q & ~IMPL_BITS) == '0));

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int unsigned W     = 32,
    parameter int unsigned IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     pending,
    output logic [IDX_W-1:0] idx,
    output logic             vld
);
    always_comb begin
        idx = '0;
        vld = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (pending[i]) begin
                idx = IDX_W'(i);
                vld = 1'b1;
            end
        end
    end

    // R8: the chosen bit is pending and nothing below it is
    a_r8_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (pending[idx] && ((pending & ((W'(1) << idx) - W'(1))) == '0)));

    a_r8_valid_iff_any: assert property (@(posedge clk) disable iff (!rst_n)
        vld == (pending != '0));

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [OFS_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [DESC_W-1:0] desc_evt,
    input  logic              bus_abort,
    input  logic              ext_irq_n,
    output logic              irq_o,
    output logic [IDX_W-1:0]  pend_idx,
    output logic              pend_vld
);
    reg_sel_e         sel;
    logic             ext_active;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] status_q, mask_q, status_n, mask_n;
    logic             en_q, en_n;
    logic             irq_q;

    assign sel = decode_ofs(reg_addr);

    irq_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_n (ext_irq_n),
        .active (ext_active)
    );

    always_comb begin
        set_vec             = '0;
        set_vec[DESC_W-1:0] = desc_evt;
        set_vec[EXT_POS]    = ext_active;
        set_vec[ABORT_POS]  = bus_abort;
    end

    irq_agg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .sel      (sel),
        .wdata    (reg_wdata),
        .set_vec  (set_vec),
        .status_q (status_q),
        .mask_q   (mask_q),
        .en_q     (en_q),
        .status_n (status_n),
        .mask_n   (mask_n),
        .en_n     (en_n)
    );

    irq_lowest_pick #(.W(REG_W), .IDX_W(IDX_W)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (status_q & mask_q),
        .idx     (pend_idx),
        .vld     (pend_vld)
    );

    // registered from next state so it lines up with the registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= ((status_n & mask_n) != '0) && en_n;
        end
    end

    assign irq_o = irq_q;

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata = status_q;
            SEL_MASK:   reg_rdata = mask_q;
            SEL_ENABLE: reg_rdata = {{(REG_W-1){1'b0}}, en_q};
            SEL_NONE:   reg_rdata = '0;
        endcase
    end

    // R6: the level matches the current register contents
    a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (((status_q & mask_q) != '0) && en_q));

    // R6: enable off means no interrupt
    a_r6_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !irq_o);

    // R4: an abort pulse shows up on the next edge
    a_r4_abort_sets: assert property (@(posedge clk) disable iff (!rst_n)
        bus_abort |=> status_q[ABORT_POS]);

endmodule

// File: tb/tb_irq_status_agg.sv
module tb_irq_status_agg;
    import irq_agg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = 12'h500;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] desc_evt = '0;
    logic        bus_abort = 1'b0;
    logic        ext_irq_n = 1'b1;
    logic        irq_o;
    logic [4:0]  pend_idx;
    logic        pend_vld;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_status_agg dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .desc_evt(desc_evt),
        .bus_abort(bus_abort), .ext_irq_n(ext_irq_n), .irq_o(irq_o),
        .pend_idx(pend_idx), .pend_vld(pend_vld)
    );

    typedef struct packed {
        logic [15:0] desc;
        logic        abort;
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] st;
        logic        irq;
        logic [4:0]  idx;
        logic        vld;
    } vec_t;

    localparam int NV = 15;
    // expected values after each step; mask read-back is 0x0600FFFF after a write of all ones
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 1'b0, 1'b1, 12'h504, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 5'd0,  1'b0}, // R2 mask all
        '{16'h0008, 1'b0, 1'b0, 12'h500, 32'h0,         32'h0000_0008, 1'b0, 5'd3,  1'b1}, // R4 R8 en off
        '{16'h0000, 1'b0, 1'b1, 12'h508, 32'h1,         32'h0000_0008, 1'b1, 5'd3,  1'b1}, // R6 enable
        '{16'h0000, 1'b1, 1'b0, 12'h500, 32'h0,         32'h0400_0008, 1'b1, 5'd3,  1'b1}, // R4 abort bit 26
        '{16'h0000, 1'b0, 1'b1, 12'h500, 32'h0000_0008, 32'h0400_0000, 1'b1, 5'd26, 1'b1}, // R3 clear bit 3
        '{16'h0200, 1'b0, 1'b1, 12'h500, 32'h0400_0200, 32'h0000_0200, 1'b1, 5'd9,  1'b1}, // R5 event beats clear
        '{16'h0000, 1'b0, 1'b1, 12'h504, 32'h0000_0001, 32'h0000_0200, 1'b0, 5'd0,  1'b0}, // R6 masked off
        '{16'h8001, 1'b0, 1'b0, 12'h500, 32'h0,         32'h0000_8201, 1'b1, 5'd0,  1'b1}, // R4 bits 0 and 15
        '{16'h0000, 1'b0, 1'b1, 12'h508, 32'h0,         32'h0000_8201, 1'b0, 5'd0,  1'b1}, // R8 valid without enable
        '{16'h0000, 1'b0, 1'b1, 12'h508, 32'h1,         32'h0000_8201, 1'b1, 5'd0,  1'b1}, // R6
        '{16'h0000, 1'b0, 1'b1, 12'h500, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 5'd0,  1'b0}, // R3 clear all
        '{16'h0010, 1'b0, 1'b0, 12'h500, 32'h0,         32'h0000_0010, 1'b0, 5'd0,  1'b0}, // R4
        '{16'h0000, 1'b0, 1'b1, 12'h500, 32'h0,         32'h0000_0010, 1'b0, 5'd0,  1'b0}, // R3 zero write keeps
        '{16'h0000, 1'b0, 1'b1, 12'h50C, 32'hFFFF_FFFF, 32'h0000_0010, 1'b0, 5'd0,  1'b0}, // R9 stray write
        '{16'h0000, 1'b0, 1'b1, 12'h504, 32'h0000_0010, 32'h0000_0010, 1'b1, 5'd4,  1'b1}  // R8 R6 unmask
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] d, input logic ab, input logic w,
                        input logic [11:0] a, input logic [31:0] wd);
        @(negedge clk);
        desc_evt = d; bus_abort = ab; reg_wr = w; reg_addr = a; reg_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        desc_evt = '0; bus_abort = 1'b0; reg_wr = 1'b0; reg_addr = 12'h500; reg_wdata = '0;
        #1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
        reg_addr = 12'h500;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        rd(12'h500, v); chk("R1 status", v, 32'h0);
        rd(12'h504, v); chk("R1 mask", v, 32'h0);
        rd(12'h508, v); chk("R1 enable", v, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        chk("R1 vld", {31'b0, pend_vld}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].desc, VECS[i].abort, VECS[i].wr, VECS[i].addr, VECS[i].wdata);
            chk($sformatf("R3/R4/R5 vec%0d status", i), reg_rdata, VECS[i].st);
            chk($sformatf("R6 vec%0d irq", i), {31'b0, irq_o}, {31'b0, VECS[i].irq});
            chk($sformatf("R8 vec%0d vld", i), {31'b0, pend_vld}, {31'b0, VECS[i].vld});
            if (VECS[i].vld)
                chk($sformatf("R8 vec%0d idx", i), {27'b0, pend_idx}, {27'b0, VECS[i].idx});
        end

        // R9 stray write left the mask alone; stray read is zero
        rd(12'h504, v); chk("R9 mask kept", v, 32'h10);
        rd(12'h50C, v); chk("R9 read zero", v, 32'h0);
        // R2 unused bits
        step(16'h0, 1'b0, 1'b1, 12'h504, 32'hFFFF_FFFF);
        rd(12'h504, v); chk("R2 mask bits", v, 32'h0600_FFFF);
        step(16'h0, 1'b0, 1'b1, 12'h508, 32'hFFFF_FFFF);
        rd(12'h508, v); chk("R2 enable bits", v, 32'h1);
        step(16'h0, 1'b0, 1'b1, 12'h500, 32'hFFFF_FFFF);
        chk("R3 cleared", reg_rdata, 32'h0);

        // R7 external line latency and stickiness
        @(negedge clk);
        ext_irq_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); #1;
        chk("R7 not yet after two edges", reg_rdata, 32'h0);
        @(posedge clk);
        @(negedge clk); #1;
        chk("R7 set on third edge", reg_rdata, 32'h0200_0000);
        chk("R7 irq", {31'b0, irq_o}, 32'h1);
        chk("R7 idx", {27'b0, pend_idx}, 32'd25);
        step(16'h0, 1'b0, 1'b1, 12'h500, 32'h0200_0000);
        chk("R7 clear while low", reg_rdata, 32'h0200_0000);
        @(negedge clk);
        ext_irq_n = 1'b1;
        repeat (3) @(posedge clk);
        step(16'h0, 1'b0, 1'b1, 12'h500, 32'h0200_0000);
        chk("R7 clear after release", reg_rdata, 32'h0);
        chk("R7 irq drops", {31'b0, irq_o}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule